// File: doc/BRIEF.md
# Low-Power Wake Sequencer

This block decides when a processor core may leave a sleep or idle state and when it may start fetching again. It watches the interrupt flags and their enables, a watchdog time-out and a reset request. It picks the wake path from the low-power mode the core entered and from the kind of primary oscillator fitted. It drives a core hold line, selects between the primary and the internal oscillator, gates the primary oscillator, and signals a branch to the interrupt vector on resume. It also sets two start-up status flags. A single input, `pri_ready`, stands in for primary oscillator stability. While the primary is enabled, each cycle with `pri_ready` high counts as one oscillator period for the start-up timer.

There are two ways out of a low-power state. A crystal or PLL primary that was stopped passes through a start-up timer of `OST_CYCLES` counted periods and then a settling delay of `SETTLE_CYCLES` cycles. A primary that kept running, or one of RC, external or internal type, skips the start-up timer and takes only the settling delay. After a reset the core can start at once on the internal oscillator if fast start is enabled. It moves to the primary when that becomes ready. All pins are plain control and status lines. There is no data stream, so no valid/ready handshake applies.

Encodings: `pwr_mode` 2'b01 primary-idle (primary kept running), 2'b10 internal-idle, 2'b11 sleep, 2'b00 not a low-power mode. `osc_kind` 3'b0xx crystal/PLL types, 3'b100 RC, 3'b101 external clock, 3'b11x internal oscillator.

Top module: `wake_seq`

## Requirements
- R1: After reset with a crystal or PLL primary and fast start off, `core_hold` stays 1 and `clk_sel_int` stays 0 until `pri_ready` is sampled high. From the next cycle `core_hold` is 0 and `osc_ready_flag` is 1, and `intosc_stable_flag` stays 0.
- R2: After reset with an internal `osc_kind` (3'b11x), `core_hold` drops on the first cycle after `reset_req` clears. From then `clk_sel_int` is 1 and `intosc_stable_flag` is 1, and `osc_ready_flag` stays 0.
- R3: With `fast_start` set and the primary not ready, the core is released on the first cycle after reset clears, with `clk_sel_int`=1 and `intosc_stable_flag`=1. The cycle after `pri_ready` is sampled high, `clk_sel_int` becomes 0 and `osc_ready_flag` becomes 1.
- R4: If the core enters any low-power mode while still running on the internal oscillator waiting for the primary, `pri_en` goes to 0 and `clk_sel_int` stays 1. The next wake then runs the full start-up timer.
- R5: An interrupt flag whose enable bit is 0 does not wake the core; `core_hold` stays 1.
- R6: A wake from sleep or internal-idle with a crystal/PLL primary holds the core for exactly `OST_CYCLES`+`SETTLE_CYCLES` cycles after the wake is sampled, with `pri_ready` high throughout. On release `clk_sel_int` is 0 and `osc_ready_flag` is 1.
- R7: A wake from primary-idle with the primary running, or with an RC, external or internal primary in any mode, holds the core for exactly `SETTLE_CYCLES` cycles.
- R8: `vector_branch` is a one-cycle pulse in the first cycle after `core_hold` falls. It is asserted only when the wake was an enabled interrupt and `gie` was 1 at the wake.
- R9: A watchdog time-out during low power wakes the core without a vector branch. During run it pulses `wdt_reset` for one cycle, raises `core_hold` and clears the status flags.
- R10: `reset_req` takes priority over an interrupt or watchdog wake sampled in the same cycle. The core goes to the reset hold with the flags cleared.
- R11: While in low power, `pri_en` is 1 only in primary-idle with the primary running and a non-internal `osc_kind`, and 0 otherwise. It is 1 again from the first wake cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_flag | input | N_IRQ | Interrupt flags |
| irq_en | input | N_IRQ | Interrupt enable bits |
| gie | input | 1 | Global interrupt enable |
| reset_req | input | 1 | Synchronous reset request |
| wdt_timeout | input | 1 | Watchdog time-out |
| sleep_enter | input | 1 | Core executes a low-power entry this cycle |
| pwr_mode | input | 2 | Low-power mode to enter |
| osc_kind | input | 3 | Primary oscillator type |
| fast_start | input | 1 | Two-speed start or fail-safe monitor enabled |
| pri_ready | input | 1 | Primary oscillator stable / counting |
| core_hold | output | 1 | Core held, no execution |
| clk_sel_int | output | 1 | 1 = internal oscillator clocks the core |
| pri_en | output | 1 | Primary oscillator enable |
| vector_branch | output | 1 | Branch to interrupt vector on resume |
| wdt_reset | output | 1 | Watchdog reset pulse |
| osc_ready_flag | output | 1 | Primary start-up completed status |
| intosc_stable_flag | output | 1 | Internal oscillator in use and stable status |

## Verification
A wrong state register or a miscounted delay shows at `core_hold` as a release one or more cycles early or late. It is visible on the wake's own release edge, at most `OST_CYCLES`+`SETTLE_CYCLES` cycles after the wake. A wrongly latched wake cause or `gie` shows as a missing or spurious `vector_branch` in that same release cycle. A stale oscillator decision shows immediately at `pri_en` on entry to low power, or as `clk_sel_int` and `osc_ready_flag` staying unchanged after release.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;

  typedef enum logic [2:0] {
    ST_RSTHOLD = 3'd0,
    ST_RUN     = 3'd1,
    ST_LOWPWR  = 3'd2,
    ST_OST     = 3'd3,
    ST_SETTLE  = 3'd4
  } seq_state_e;

  localparam logic [1:0] PM_NONE     = 2'b00;
  localparam logic [1:0] PM_PRI_IDLE = 2'b01;
  localparam logic [1:0] PM_INT_IDLE = 2'b10;
  localparam logic [1:0] PM_SLEEP    = 2'b11;

  // crystal and PLL types need the start-up timer
  function automatic logic osc_is_crystal(input logic [2:0] kind);
    return !kind[2];
  endfunction

  function automatic logic osc_is_internal(input logic [2:0] kind);
    return kind[2] & kind[1];
  endfunction

endpackage

// File: rtl/wake_detect.sv
module wake_detect #(
  parameter int N_IRQ = 8
) (
  input  logic [N_IRQ-1:0] irq_flag,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             wdt_timeout,
  output logic             irq_wake,
  output logic             wdt_wake
);
  logic [N_IRQ-1:0] masked;

  for (genvar gi = 0; gi < N_IRQ; gi++) begin : g_mask
    assign masked[gi] = irq_flag[gi] & irq_en[gi];
  end

  assign irq_wake = |masked;
  assign wdt_wake = wdt_timeout;
endmodule

// File: rtl/wake_delay_ctr.sv
module wake_delay_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (en)   cnt <= cnt + 1'b1;
  end

  assign last = en && (cnt == limit - 1'b1);
endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
  import wake_seq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         irq_wake,
  input  logic         wdt_wake,
  input  logic         gie,
  input  logic         reset_req,
  input  logic         sleep_enter,
  input  logic [1:0]   pwr_mode,
  input  logic [2:0]   osc_kind,
  input  logic         fast_start,
  input  logic         pri_ready,
  input  logic         ctr_last,
  input  logic [W-1:0] ost_limit,
  input  logic [W-1:0] settle_limit,
  output logic         ctr_clr,
  output logic         ctr_en,
  output logic [W-1:0] ctr_limit,
  output logic         core_hold,
  output logic         clk_sel_int,
  output logic         pri_en,
  output logic         vector_branch,
  output logic         wdt_reset,
  output logic         osc_ready_flag,
  output logic         intosc_stable_flag
);
  seq_state_e state;
  logic       pend_q;      // running on internal, waiting for primary
  logic       cause_irq_q;
  logic       gie_q;
  logic       is_xtal, is_int;

  assign is_xtal = osc_is_crystal(osc_kind);
  assign is_int  = osc_is_internal(osc_kind);

  // counter control
  assign ctr_en    = ((state == ST_OST) && pri_ready) || (state == ST_SETTLE);
  assign ctr_limit = (state == ST_OST) ? ost_limit : settle_limit;
  assign ctr_clr   = !((state == ST_OST) || (state == ST_SETTLE))
                     || ((state == ST_OST) && ctr_last);

  assign core_hold = (state != ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state              <= ST_RSTHOLD;
      pend_q             <= 1'b0;
      cause_irq_q        <= 1'b0;
      gie_q              <= 1'b0;
      clk_sel_int        <= 1'b0;
      pri_en             <= 1'b1;
      vector_branch      <= 1'b0;
      wdt_reset          <= 1'b0;
      osc_ready_flag     <= 1'b0;
      intosc_stable_flag <= 1'b0;
    end else begin
      vector_branch <= 1'b0;
      wdt_reset     <= 1'b0;
      if (reset_req) begin
        state              <= ST_RSTHOLD;
        pend_q             <= 1'b0;
        clk_sel_int        <= 1'b0;
        pri_en             <= 1'b1;
        osc_ready_flag     <= 1'b0;
        intosc_stable_flag <= 1'b0;
      end else begin
        unique case (state)
          ST_RSTHOLD: begin
            if (is_int) begin
              state              <= ST_RUN;
              clk_sel_int        <= 1'b1;
              intosc_stable_flag <= 1'b1;
            end else if (pri_ready) begin
              state          <= ST_RUN;
              clk_sel_int    <= 1'b0;
              osc_ready_flag <= 1'b1;
            end else if (fast_start) begin
              state              <= ST_RUN;
              clk_sel_int        <= 1'b1;
              intosc_stable_flag <= 1'b1;
              pend_q             <= 1'b1;
            end
          end
          ST_RUN: begin
            if (wdt_wake) begin
              state              <= ST_RSTHOLD;
              wdt_reset          <= 1'b1;
              pend_q             <= 1'b0;
              clk_sel_int        <= 1'b0;
              pri_en             <= 1'b1;
              osc_ready_flag     <= 1'b0;
              intosc_stable_flag <= 1'b0;
            end else if (sleep_enter && (pwr_mode != PM_NONE)) begin
              state  <= ST_LOWPWR;
              pend_q <= 1'b0;
              pri_en <= (pwr_mode == PM_PRI_IDLE) && !pend_q && !is_int;
            end else if (pend_q && pri_ready) begin
              pend_q         <= 1'b0;
              clk_sel_int    <= 1'b0;
              osc_ready_flag <= 1'b1;
            end
          end
          ST_LOWPWR: begin
            if (irq_wake || wdt_wake) begin
              cause_irq_q <= irq_wake;
              gie_q       <= gie;
              pri_en      <= 1'b1;
              if (!is_xtal) begin
                state       <= ST_SETTLE;
                clk_sel_int <= is_int;
              end else if (pri_en) begin
                state <= ST_SETTLE;
              end else begin
                state <= ST_OST;
              end
            end
          end
          ST_OST: begin
            if (ctr_last) begin
              state          <= ST_SETTLE;
              clk_sel_int    <= 1'b0;
              osc_ready_flag <= 1'b1;
            end
          end
          ST_SETTLE: begin
            if (ctr_last) begin
              state         <= ST_RUN;
              vector_branch <= cause_irq_q && gie_q;
            end
          end
          default: state <= ST_RSTHOLD;
        endcase
      end
    end
  end
endmodule

// File: rtl/wake_seq.sv
module wake_seq
  import wake_seq_pkg::*;
#(
  parameter int N_IRQ         = 8,
  parameter int OST_CYCLES    = 1024,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_flag,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             gie,
  input  logic             reset_req,
  input  logic             wdt_timeout,
  input  logic             sleep_enter,
  input  logic [1:0]       pwr_mode,
  input  logic [2:0]       osc_kind,
  input  logic             fast_start,
  input  logic             pri_ready,
  output logic             core_hold,
  output logic             clk_sel_int,
  output logic             pri_en,
  output logic             vector_branch,
  output logic             wdt_reset,
  output logic             osc_ready_flag,
  output logic             intosc_stable_flag
);
  localparam int MAXC = (OST_CYCLES > SETTLE_CYCLES) ? OST_CYCLES : SETTLE_CYCLES;
  localparam int W    = $clog2(MAXC + 1);
  localparam logic [W-1:0] OST_LIM    = W'(OST_CYCLES);
  localparam logic [W-1:0] SETTLE_LIM = W'(SETTLE_CYCLES);

  logic         irq_wake, wdt_wake;
  logic         ctr_clr, ctr_en, ctr_last;
  logic [W-1:0] ctr_limit;

  wake_detect #(.N_IRQ(N_IRQ)) u_detect (
    .irq_flag    (irq_flag),
    .irq_en      (irq_en),
    .wdt_timeout (wdt_timeout),
    .irq_wake    (irq_wake),
    .wdt_wake    (wdt_wake)
  );

  wake_delay_ctr #(.W(W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctr_clr),
    .en    (ctr_en),
    .limit (ctr_limit),
    .last  (ctr_last)
  );

  wake_fsm #(.W(W)) u_fsm (
    .clk                (clk),
    .rst_n              (rst_n),
    .irq_wake           (irq_wake),
    .wdt_wake           (wdt_wake),
    .gie                (gie),
    .reset_req          (reset_req),
    .sleep_enter        (sleep_enter),
    .pwr_mode           (pwr_mode),
    .osc_kind           (osc_kind),
    .fast_start         (fast_start),
    .pri_ready          (pri_ready),
    .ctr_last           (ctr_last),
    .ost_limit          (OST_LIM),
    .settle_limit       (SETTLE_LIM),
    .ctr_clr            (ctr_clr),
    .ctr_en             (ctr_en),
    .ctr_limit          (ctr_limit),
    .core_hold          (core_hold),
    .clk_sel_int        (clk_sel_int),
    .pri_en             (pri_en),
    .vector_branch      (vector_branch),
    .wdt_reset          (wdt_reset),
    .osc_ready_flag     (osc_ready_flag),
    .intosc_stable_flag (intosc_stable_flag)
  );
endmodule

// File: rtl/wake_seq_checker.sv
module wake_seq_checker (
  input logic clk,
  input logic rst_n,
  input logic reset_req,
  input logic core_hold,
  input logic clk_sel_int,
  input logic pri_en,
  input logic vector_branch,
  input logic wdt_reset,
  input logic osc_ready_flag
);
  assert_branch_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vector_branch |-> !core_hold);

  assert_branch_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vector_branch |=> !vector_branch);

  assert_reset_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (core_hold && !osc_ready_flag && !vector_branch));

  assert_wdt_reset_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |-> (core_hold && !osc_ready_flag));

  assert_primary_off_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_en |-> core_hold);

  assert_ready_on_primary_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_ready_flag) |-> !clk_sel_int);
endmodule

bind wake_seq wake_seq_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reset_req      (reset_req),
  .core_hold      (core_hold),
  .clk_sel_int    (clk_sel_int),
  .pri_en         (pri_en),
  .vector_branch  (vector_branch),
  .wdt_reset      (wdt_reset),
  .osc_ready_flag (osc_ready_flag)
);

// File: tb/wake_seq_bench.sv
module wake_seq_bench;
  localparam int NI  = 4;
  localparam int OST = 6;
  localparam int STL = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] irq_flag = '0, irq_en = '0;
  logic          gie = 1'b0, reset_req = 1'b0, wdt_timeout = 1'b0, sleep_enter = 1'b0;
  logic [1:0]    pwr_mode = 2'b11;
  logic [2:0]    osc_kind = 3'b000;
  logic          fast_start = 1'b0, pri_ready = 1'b0;
  logic          core_hold, clk_sel_int, pri_en, vector_branch, wdt_reset;
  logic          osc_ready_flag, intosc_stable_flag;
  int            nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  wake_seq #(.N_IRQ(NI), .OST_CYCLES(OST), .SETTLE_CYCLES(STL)) u_wake_seq (
    .clk(clk), .rst_n(rst_n), .irq_flag(irq_flag), .irq_en(irq_en), .gie(gie),
    .reset_req(reset_req), .wdt_timeout(wdt_timeout), .sleep_enter(sleep_enter),
    .pwr_mode(pwr_mode), .osc_kind(osc_kind), .fast_start(fast_start),
    .pri_ready(pri_ready), .core_hold(core_hold), .clk_sel_int(clk_sel_int),
    .pri_en(pri_en), .vector_branch(vector_branch), .wdt_reset(wdt_reset),
    .osc_ready_flag(osc_ready_flag), .intosc_stable_flag(intosc_stable_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_reset();
    @(negedge clk) reset_req = 1'b1;
    @(negedge clk) reset_req = 1'b0;
  endtask

  // bring core to run on primary (or internal kind) with no pending switch
  task automatic to_run(input logic [2:0] k);
    osc_kind = k; fast_start = 1'b0; pri_ready = 1'b1;
    pulse_reset();
    @(negedge clk);
  endtask

  task automatic enter_lp(input logic [1:0] m);
    pwr_mode = m; sleep_enter = 1'b1;
    @(negedge clk) sleep_enter = 1'b0;
  endtask

  // raise wake now, return number of held cycles and branch pulse
  task automatic wake(input bit by_irq, output int held, output int vec, output int vec_after);
    if (by_irq) begin irq_flag[1] = 1'b1; irq_en[1] = 1'b1; end
    else wdt_timeout = 1'b1;
    held = 0;
    @(negedge clk);
    irq_flag = '0; wdt_timeout = 1'b0;
    while (core_hold && held < 200) begin
      held++;
      @(negedge clk);
    end
    vec = int'(vector_branch);
    @(negedge clk);
    vec_after = int'(vector_branch);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int held, vec, va;
    repeat (3) @(negedge clk);
    // reset state
    chk("reset core_hold", int'(core_hold), 1);
    chk("reset osc_ready", int'(osc_ready_flag), 0);
    chk("reset pri_en", int'(pri_en), 1);
    rst_n = 1'b1;

    // R1: crystal, held until primary ready
    osc_kind = 3'b010; pri_ready = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 hold before ready", int'(core_hold), 1);
    chk("R1 clk primary", int'(clk_sel_int), 0);
    pri_ready = 1'b1;
    @(negedge clk);
    chk("R1 release", int'(core_hold), 0);
    chk("R1 osc_ready", int'(osc_ready_flag), 1);
    chk("R1 intosc flag", int'(intosc_stable_flag), 0);

    // R2: internal kind releases at once
    osc_kind = 3'b110; pri_ready = 1'b0;
    pulse_reset();
    @(negedge clk);
    chk("R2 release", int'(core_hold), 0);
    chk("R2 clk internal", int'(clk_sel_int), 1);
    chk("R2 intosc flag", int'(intosc_stable_flag), 1);
    chk("R2 osc_ready", int'(osc_ready_flag), 0);

    // R3: fast start
    osc_kind = 3'b001; fast_start = 1'b1; pri_ready = 1'b0;
    pulse_reset();
    @(negedge clk);
    chk("R3 early release", int'(core_hold), 0);
    chk("R3 clk internal", int'(clk_sel_int), 1);
    chk("R3 intosc flag", int'(intosc_stable_flag), 1);
    pri_ready = 1'b1;
    @(negedge clk);
    chk("R3 switch to primary", int'(clk_sel_int), 0);
    chk("R3 osc_ready", int'(osc_ready_flag), 1);

    // R4: low power entered while switch pending
    pri_ready = 1'b0;
    pulse_reset();
    @(negedge clk);
    enter_lp(2'b01);
    chk("R4 primary off", int'(pri_en), 0);
    chk("R4 still internal", int'(clk_sel_int), 1);
    pri_ready = 1'b1; gie = 1'b0;
    wake(1'b1, held, vec, va);
    chk("R4 full start-up", held, OST + STL);
    chk("R4 primary after", int'(clk_sel_int), 0);

    // R5: disabled interrupt ignored
    to_run(3'b000);
    enter_lp(2'b11);
    irq_flag = 4'b1000; irq_en = 4'b0111;
    repeat (6) @(negedge clk);
    chk("R5 masked irq no wake", int'(core_hold), 1);
    irq_flag = '0; irq_en = '0;
    wake(1'b1, held, vec, va);
    chk("R5 enabled irq wakes", held, OST + STL);

    // R6/R7/R8/R9/R11 sweep over kinds, modes, gie, cause
    for (int k = 0; k < 8; k++) begin
      for (int m = 1; m < 4; m++) begin
        for (int c = 0; c < 4; c++) begin
          bit xtal, intk, byirq, g;
          int exp_held, exp_pri;
          xtal  = (k < 4);
          intk  = (k >= 6);
          byirq = c[0];
          g     = c[1];
          to_run(3'(k));
          gie = g;
          enter_lp(2'(m));
          exp_pri = (m == 1 && !intk) ? 1 : 0;
          chk($sformatf("R11 pri_en lp k%0d m%0d", k, m), int'(pri_en), exp_pri);
          exp_held = (xtal && m != 1) ? OST + STL : STL;
          wake(byirq, held, vec, va);
          chk($sformatf("%s hold k%0d m%0d", (exp_held == STL) ? "R7" : "R6", k, m),
              held, exp_held);
          chk($sformatf("R8 branch k%0d m%0d c%0d", k, m, c), vec, (byirq && g) ? 1 : 0);
          chk("R8 branch one cycle", va, 0);
          chk("R11 pri_en after wake", int'(pri_en), 1);
          if (xtal && m != 1) chk("R6 osc_ready", int'(osc_ready_flag), 1);
          if (!byirq) chk("R9 wdt wake no reset pulse", int'(wdt_reset), 0);
        end
      end
    end

    // R9: watchdog while running
    to_run(3'b000);
    pri_ready = 1'b0;
    @(negedge clk) wdt_timeout = 1'b1;
    @(negedge clk) wdt_timeout = 1'b0;
    chk("R9 wdt_reset pulse", int'(wdt_reset), 1);
    chk("R9 hold", int'(core_hold), 1);
    chk("R9 flag cleared", int'(osc_ready_flag), 0);
    @(negedge clk);
    chk("R9 pulse ends", int'(wdt_reset), 0);

    // R10: reset beats interrupt wake in same cycle
    to_run(3'b000);
    enter_lp(2'b11);
    pri_ready = 1'b0; gie = 1'b1;
    irq_flag[0] = 1'b1; irq_en[0] = 1'b1; reset_req = 1'b1;
    @(negedge clk);
    irq_flag = '0; reset_req = 1'b0;
    repeat (OST + STL + 3) @(negedge clk);
    chk("R10 still held", int'(core_hold), 1);
    chk("R10 flag cleared", int'(osc_ready_flag), 0);
    chk("R10 no branch", int'(vector_branch), 0);
    pri_ready = 1'b1;
    @(negedge clk);
    chk("R10 released by ready", int'(core_hold), 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule